// File: doc/BRIEF.md
# Incremental LT Peeling Decoder

This block recovers up to `K` information bits from a received LT codeword of up to `N` bits. It uses hard-decision peeling. The code graph is a fixed rule shared with the encoder. Each code symbol is the XOR of the information bits it connects to.

A frame strobe captures four things: the received word, the information length `k`, the step size `inc` and the usable codeword length `n`. The first attempt peels using only the lowest `k` code symbols. If peeling stalls before every information bit is resolved, the active length grows by `inc` (capped at `n`) and the working graph is rebuilt from the received values. Peeling then restarts.

The result is reported with a one-cycle done pulse and a success flag. Information bits that peeling never resolved read as zero.

Each peel step runs through a fixed state sequence:
1. Search for the lowest code symbol that has exactly one remaining neighbour.
2. Find that neighbour.
3. Copy the symbol value into it.
4. Cancel the resolved bit out of every other symbol that references it.
5. Re-check for work.

Top module: `lt_peel_dec`

## Requirements
- R1: While `rst_ni` is low and after reset, `done_o`, `ok_o` and `data_o` are all zero.
- R2: Code symbol j is connected to information bit i (for i < k) exactly when i equals (7*j) mod K, or when (i*j + 3*i + 2*j + 3) mod 5 equals 0. Bit j of `data_i` is code symbol j.
- R3: For an error-free codeword, a decode reported with `ok_o`=1 returns the original information bits on `data_o`. Bit i of `data_o` is information bit i.
- R4: The first attempt uses code symbols 0..k-1. After each stall the active length grows by `inc`, capped at `n`, and the graph is rebuilt from the received values. Received bits at or above the final active length never change the result.
- R5: Every search takes the lowest matching index: first the lowest code symbol with one neighbour, then its single neighbour. For a corrupted word, the result therefore equals lowest-first peeling.
- R6: When the last attempt ends with an unresolved bit below k, `ok_o` is 0. Unresolved bits, and all bits at or above k, read as zero.
- R7: `done_o` is high for exactly one cycle per accepted frame. `data_o` and `ok_o` hold their previous values until that cycle and keep the new values afterwards.
- R8: A `frame_i` pulse while a decode is in progress is ignored: it changes neither the result nor the captured lengths.
- R9: Lengths are saturated as follows:
  - `k_i` above K is taken as K.
  - `n_i` above N is taken as N.
  - An `n` below k is taken as k.
  - `inc_i`=0 ends the decode after the first attempt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| k_i | input | $clog2(K+1) | Information length for the frame |
| inc_i | input | $clog2(N+1) | Symbols added per retry |
| n_i | input | $clog2(N+1) | Maximum codeword length to use |
| data_i | input | N | Received codeword, bit j = code symbol j |
| frame_i | input | 1 | Capture strobe, accepted when idle |
| data_o | output | K | Decoded information bits |
| done_o | output | 1 | One-cycle completion pulse |
| ok_o | output | 1 | All k bits resolved (valid from done) |

## Verification
The embedded assertions run on every cycle and check the structural invariants of a peel step:
- A selected code symbol really has a single neighbour, and that neighbour is found.
- Cancelling a resolved bit leaves no code symbol referencing it.
- Each retry strictly raises the active length without passing `n`.
- The captured frame stays frozen while busy.
- A success flag only accompanies full coverage.
- Done never lasts two cycles.

Only the bench scenarios can show that the decoded values are correct. These scenarios cover clean words, corrupted words resolved in lowest-first order, retry growth with different `k`/`inc`/`n` mixes, tail bits that must not matter, saturation of the lengths, and frames dropped while busy. The bench compares each against an independent peeling model.

// File: rtl/lt_dec_pkg.sv
package lt_dec_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_INIT,
    ST_FIND_CUR,
    ST_FIND_COV,
    ST_RELEASE,
    ST_COVER,
    ST_SET,
    ST_CHECK,
    ST_INC_TEST,
    ST_AGAIN,
    ST_END
  } dec_state_e;

  // fixed code graph shared with the encoder
  function automatic logic lt_edge(int sym, int bit_i, int kmax);
    return (bit_i == (7 * sym) % kmax) || ((((bit_i + 1) * (sym + 3) + sym) % 5) == 0);
  endfunction

endpackage

// File: rtl/lt_first_set.sv
module lt_first_set #(
  parameter int W = 8,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = |vec_i;
    idx_o   = '0;
    for (int b = W - 1; b >= 0; b--) begin
      if (vec_i[b]) idx_o = IW'(b);
    end
  end
endmodule

// File: rtl/lt_adj_build.sv
module lt_adj_build
  import lt_dec_pkg::*;
#(
  parameter int K = 12,
  parameter int N = 24,
  localparam int NW = $clog2(N + 1)
) (
  input  logic [NW-1:0]        len_i,
  input  logic [NW-1:0]        k_i,
  output logic [N-1:0][K-1:0]  adj_o
);
  for (genvar j = 0; j < N; j++) begin : g_sym
    localparam logic [NW-1:0] JV = NW'(j);
    for (genvar i = 0; i < K; i++) begin : g_bit
      localparam logic          E  = lt_edge(j, i, K);
      localparam logic [NW-1:0] IV = NW'(i);
      if (E) begin : g_on
        assign adj_o[j][i] = (len_i > JV) && (k_i > IV);
      end else begin : g_off
        assign adj_o[j][i] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/lt_deg_one.sv
module lt_deg_one #(
  parameter int K = 12,
  parameter int N = 24
) (
  input  logic [N-1:0][K-1:0] adj_i,
  output logic [N-1:0]        deg1_o
);
  for (genvar j = 0; j < N; j++) begin : g_row
    assign deg1_o[j] = ($countones(adj_i[j]) == 1);
  end
endmodule

// File: rtl/lt_peel_dec.sv
module lt_peel_dec
  import lt_dec_pkg::*;
#(
  parameter int K = 12,
  parameter int N = 24,
  localparam int KW = $clog2(K + 1),
  localparam int NW = $clog2(N + 1),
  localparam int KI = (K > 1) ? $clog2(K) : 1,
  localparam int NI = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [KW-1:0] k_i,
  input  logic [NW-1:0] inc_i,
  input  logic [NW-1:0] n_i,
  input  logic [N-1:0]  data_i,
  input  logic          frame_i,
  output logic [K-1:0]  data_o,
  output logic          done_o,
  output logic          ok_o
);
  dec_state_e         state_q;
  logic [N-1:0]       rx_q, val_q;
  logic [N-1:0][K-1:0] adj_q, adj_rebuild;
  logic [K-1:0]       info_q, cov_q, out_q, kmask;
  logic               ok_q;
  logic [NW-1:0]      k_q, inc_q, n_q, len_q;
  logic [NI-1:0]      cur_q, cur_idx;
  logic [KI-1:0]      covi_q, cov_idx;
  logic [N-1:0]       deg1, col_hit;
  logic               any_deg1, cov_found;

  // length saturation at capture
  logic [NW-1:0] k_sat, n_sat, n_lim;
  always_comb begin
    k_sat = (int'(k_i) > K) ? NW'(K) : NW'(k_i);
    n_lim = (int'(n_i) > N) ? NW'(N) : n_i;
    n_sat = (n_lim < k_sat) ? k_sat : n_lim;
  end

  logic [NW:0]   len_sum;
  logic [NW-1:0] len_next;
  always_comb begin
    len_sum  = {1'b0, len_q} + {1'b0, inc_q};
    len_next = (len_sum > {1'b0, n_q}) ? n_q : len_sum[NW-1:0];
  end

  for (genvar i = 0; i < K; i++) begin : g_kmask
    assign kmask[i] = (k_q > NW'(i));
  end

  always_comb begin
    for (int j = 0; j < N; j++) col_hit[j] = adj_q[j][covi_q];
  end

  logic all_cov;
  assign all_cov = &(cov_q | ~kmask);

  lt_adj_build #(.K(K), .N(N)) u_adj (
    .len_i (len_q),
    .k_i   (k_q),
    .adj_o (adj_rebuild)
  );

  lt_deg_one #(.K(K), .N(N)) u_deg (
    .adj_i  (adj_q),
    .deg1_o (deg1)
  );

  lt_first_set #(.W(N)) u_find_cur (
    .vec_i   (deg1),
    .found_o (any_deg1),
    .idx_o   (cur_idx)
  );

  lt_first_set #(.W(K)) u_find_cov (
    .vec_i   (adj_q[cur_q]),
    .found_o (cov_found),
    .idx_o   (cov_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rx_q    <= '0;
      val_q   <= '0;
      adj_q   <= '0;
      info_q  <= '0;
      cov_q   <= '0;
      out_q   <= '0;
      ok_q    <= 1'b0;
      k_q     <= '0;
      inc_q   <= '0;
      n_q     <= '0;
      len_q   <= '0;
      cur_q   <= '0;
      covi_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (frame_i) begin
          rx_q    <= data_i;
          k_q     <= k_sat;
          inc_q   <= inc_i;
          n_q     <= n_sat;
          len_q   <= k_sat;
          state_q <= ST_INIT;
        end
        ST_INIT: begin
          adj_q   <= adj_rebuild;
          val_q   <= rx_q;
          info_q  <= '0;
          cov_q   <= '0;
          state_q <= ST_FIND_CUR;
        end
        ST_FIND_CUR: begin
          cur_q   <= cur_idx;
          state_q <= any_deg1 ? ST_FIND_COV : ST_INC_TEST;
        end
        ST_FIND_COV: begin
          covi_q  <= cov_idx;
          state_q <= ST_RELEASE;
        end
        ST_RELEASE: begin
          info_q[covi_q]        <= val_q[cur_q];
          cov_q[covi_q]         <= 1'b1;
          adj_q[cur_q][covi_q]  <= 1'b0;
          state_q               <= ST_COVER;
        end
        ST_COVER: begin
          for (int j = 0; j < N; j++) begin
            if (adj_q[j][covi_q]) begin
              val_q[j]         <= val_q[j] ^ info_q[covi_q];
              adj_q[j][covi_q] <= 1'b0;
            end
          end
          state_q <= ST_SET;
        end
        ST_SET: begin
          cur_q   <= '0;
          covi_q  <= '0;
          state_q <= ST_CHECK;
        end
        ST_CHECK: state_q <= any_deg1 ? ST_FIND_CUR : ST_INC_TEST;
        ST_INC_TEST: begin
          if (all_cov || len_q >= n_q || inc_q == '0) begin
            out_q   <= info_q & cov_q & kmask;
            ok_q    <= all_cov;
            state_q <= ST_END;
          end else begin
            state_q <= ST_AGAIN;
          end
        end
        ST_AGAIN: begin
          len_q   <= len_next;
          state_q <= ST_INIT;
        end
        ST_END:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign data_o = out_q;
  assign ok_o   = ok_q;
  assign done_o = (state_q == ST_END);

  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r6_ok_full_cover: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && ok_o) |-> all_cov);
  a_r5_single_neighbour: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FIND_COV) |-> (cov_found && $countones(adj_q[cur_q]) == 1));
  a_r3_column_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SET) |-> (col_hit == '0 && cov_q[covi_q]));
  a_r4_len_grows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_AGAIN) |=> (len_q > $past(len_q) && len_q <= n_q));
  a_r8_busy_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> ($stable(k_q) && $stable(rx_q) && $stable(n_q)));
endmodule

// File: tb/sim_lt_peel_dec.sv
module sim_lt_peel_dec;
  localparam int K  = 12;
  localparam int N  = 24;
  localparam int KW = $clog2(K + 1);
  localparam int NW = $clog2(N + 1);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [KW-1:0] k_i = '0;
  logic [NW-1:0] inc_i = '0;
  logic [NW-1:0] n_i = '0;
  logic [N-1:0]  data_i = '0;
  logic          frame_i = 1'b0;
  logic [K-1:0]  data_o;
  logic          done_o, ok_o;

  int total = 0;
  int bad   = 0;

  always #4 clk_i = ~clk_i;

  lt_peel_dec #(.K(K), .N(N)) u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R2 graph, written in expanded form
  function automatic bit link(int j, int i);
    return (i == (j * 7) % K) || (((i * j + 3 * i + 2 * j + 3) % 5) == 0);
  endfunction

  function automatic logic [N-1:0] encode(logic [K-1:0] info, int k);
    logic [N-1:0] cw = '0;
    for (int j = 0; j < N; j++)
      for (int i = 0; i < k; i++)
        if (link(j, i)) cw[j] ^= info[i];
    return cw;
  endfunction

  // behavioural lowest-first peeling with retries
  task automatic model(input logic [N-1:0] rx, input int k_in, input int inc, input int n_in,
                       output logic [K-1:0] res, output bit ok);
    int k, n, len;
    bit a [N][K];
    bit v [N];
    logic [K-1:0] got, cov;
    k = (k_in > K) ? K : k_in;
    n = (n_in > N) ? N : n_in;
    if (n < k) n = k;
    len = k;
    forever begin
      got = '0; cov = '0;
      for (int j = 0; j < N; j++) begin
        v[j] = rx[j];
        for (int i = 0; i < K; i++) a[j][i] = (j < len) && (i < k) && link(j, i);
      end
      forever begin
        int pick, nb, cnt;
        pick = -1;
        for (int j = 0; j < N && pick < 0; j++) begin
          cnt = 0;
          for (int i = 0; i < K; i++) if (a[j][i]) begin cnt++; nb = i; end
          if (cnt == 1) pick = j;
        end
        if (pick < 0) break;
        for (int i = 0; i < K; i++) if (a[pick][i]) nb = i;
        got[nb] = v[pick]; cov[nb] = 1'b1; a[pick][nb] = 1'b0;
        for (int j = 0; j < N; j++) if (a[j][nb]) begin v[j] ^= got[nb]; a[j][nb] = 1'b0; end
      end
      ok = 1'b1;
      for (int i = 0; i < k; i++) if (!cov[i]) ok = 1'b0;
      if (ok || len >= n || inc == 0) break;
      len = (len + inc > n) ? n : len + inc;
    end
    res = got & cov;
  endtask

  task automatic run(input logic [N-1:0] rx, input int k, input int inc, input int n,
                     input bit glitch, output logic [K-1:0] got, output bit gok);
    logic [K-1:0] prev_d;
    logic         prev_ok;
    int  cyc;
    bit  held;
    @(negedge clk_i);
    k_i = KW'(k); inc_i = NW'(inc); n_i = NW'(n); data_i = rx; frame_i = 1'b1;
    @(negedge clk_i);
    frame_i = 1'b0; data_i = ~rx;
    prev_d = data_o; prev_ok = ok_o; cyc = 0; held = 1'b1;
    while (!done_o && cyc < 5000) begin
      if (data_o !== prev_d || ok_o !== prev_ok) held = 1'b0;
      if (glitch && cyc == 2) begin frame_i = 1'b1; k_i = KW'(3); data_i = rx ^ 24'h5A5A5A; end
      else frame_i = 1'b0;
      @(negedge clk_i);
      cyc++;
    end
    frame_i = 1'b0;
    chk("R7 done seen", {31'd0, done_o}, 32'd1);
    chk("R7 outputs held while busy", {31'd0, held}, 32'd1);
    got = data_o; gok = ok_o;
    @(negedge clk_i);
    chk("R7 done one cycle", {31'd0, done_o}, 32'd0);
    chk("R7 result kept", {20'd0, data_o}, {20'd0, got});
  endtask

  task automatic case_chk(input string tag, input logic [N-1:0] rx, input int k,
                          input int inc, input int n, input bit glitch);
    logic [K-1:0] got, exp;
    bit gok, eok;
    run(rx, k, inc, n, glitch, got, gok);
    model(rx, k, inc, n, exp, eok);
    chk({tag, " data"}, {20'd0, got}, {20'd0, exp});
    chk({tag, " ok"}, {31'd0, gok}, {31'd0, eok});
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [K-1:0] info, g1, g2, exp;
    bit o1, o2, eok;
    logic [N-1:0] cw;
    repeat (3) @(negedge clk_i);
    chk("R1 done in reset", {31'd0, done_o}, 32'd0);
    chk("R1 ok in reset", {31'd0, ok_o}, 32'd0);
    chk("R1 data in reset", {20'd0, data_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 data after reset", {20'd0, data_o}, 32'd0);

    // R2/R3 clean words at default lengths
    for (int t = 0; t < 6; t++) begin
      info = 12'hA5C ^ K'(t * 12'h137);
      cw = encode(info, 12);
      run(cw, 12, 6, 24, 1'b0, g1, o1);
      model(cw, 12, 6, 24, exp, eok);
      chk("R2 clean data vs model", {20'd0, g1}, {20'd0, exp});
      chk("R3 clean ok vs model", {31'd0, o1}, {31'd0, eok});
      if (o1) chk("R3 clean word recovered", {20'd0, g1}, {20'd0, info});
    end

    // R4 other length mixes
    case_chk("R4 k8 inc4 n20", encode(12'h0B7, 8), 8, 4, 20, 1'b0);
    case_chk("R4 k6 inc3 n24", encode(12'h02D, 6), 6, 3, 24, 1'b0);
    case_chk("R4 k12 inc1 n24", encode(12'hF0F, 12), 12, 1, 24, 1'b0);

    // R4 tail beyond n never matters
    cw = encode(12'h3C9, 12);
    run(cw, 12, 6, 18, 1'b0, g1, o1);
    run(cw ^ 24'hFC0000, 12, 6, 18, 1'b0, g2, o2);
    chk("R4 tail ignored data", {20'd0, g2}, {20'd0, g1});
    chk("R4 tail ignored ok", {31'd0, o2}, {31'd0, o1});

    // R5 corrupted words follow lowest-first order
    case_chk("R5 corrupt a", encode(12'h5E1, 12) ^ 24'h008004, 12, 6, 24, 1'b0);
    case_chk("R5 corrupt b", encode(12'h999, 12) ^ 24'h100201, 12, 6, 24, 1'b0);

    // R6 short budget, bits above k stay zero
    case_chk("R6 no retry budget", encode(12'hFFF, 12), 12, 6, 12, 1'b0);
    run(encode(12'h0FF, 5) ^ 24'hFFFFFF, 5, 2, 9, 1'b0, g1, o1);
    chk("R6 bits above k zero", {20'd0, g1 & 12'hFE0}, 32'd0);

    // R9 saturation and zero increment
    case_chk("R9 k and n saturate", encode(12'h6D2, 12), 15, 6, 30, 1'b0);
    case_chk("R9 inc zero", encode(12'h6D2, 12), 12, 0, 24, 1'b0);
    case_chk("R9 n below k", encode(12'h1A4, 10), 10, 4, 3, 1'b0);

    // R8 frame while busy
    case_chk("R8 busy frame ignored", encode(12'h7B3, 12), 12, 6, 24, 1'b1);
    @(negedge clk_i);
    chk("R8 no extra decode", {31'd0, done_o}, 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule